// File: doc/BRIEF.md
# GPIO Interrupt Event Detector and Status Aggregator

This block watches a set of already-synchronized general-purpose input pins and turns selected transitions or levels on them into latched interrupt status. Each pin carries two configuration bits from its pin controller: a level/edge select and a polarity invert. Together they pick one of four triggers: rising edge, falling edge, low level or high level. A pin only takes part when its input sensing is on and its use-select says it is a general-purpose pin.

Every detected event sets a per-pin status bit. Status and enable bits sit in 32-bit words on the same simple register bus as the rest of the GPIO controller. Software clears status by writing ones. A single registered interrupt line is raised whenever any pin has both its status bit and its enable bit set. The last bank is only partly filled. Bits above the last pin do not exist: they read as zero and ignore writes.

Top module: `gpio_irq_detect`

## Requirements
- R1: With level select 0 and invert 0, a 0-to-1 change on a pin sets that pin's status bit at the first clock edge that sees the new value. A 1-to-0 change sets nothing.
- R2: With level select 0 and invert 1, a 1-to-0 change on a pin sets its status bit at the first clock edge that sees it. A 0-to-1 change sets nothing.
- R3: With level select 1 and invert 0, the status bit is set on every clock edge while the pin is low. A clearing write has no lasting effect until the pin goes high.
- R4: With level select 1 and invert 1, the status bit is set on every clock edge while the pin is high. A clearing write has no lasting effect until the pin goes low.
- R5: No event is detected for a pin whose sense-disable input is 1 or whose general-purpose-mode input is 0.
- R6: Status word k is at byte address 0x80+4k and enable word k is at 0x90+4k, with pin n at bit n%32 of word n/32. A read returns its data on rdata_o after the clock edge that accepts the request. Any other address reads 0 and ignores writes. Enable words are read/write.
- R7: Writing a 1 to a status bit clears it and writing 0 leaves it unchanged, so writing all ones clears a whole word.
- R8: If a new event and a clearing write hit the same status bit at the same clock edge, the bit stays set.
- R9: irq_o is a register that takes the OR, over all pins, of status AND enable. It rises one clock edge after the status bit it reflects, and a set status bit without its enable bit does not raise it.
- R10: Bit 31 of the third status word and bit 31 of the third enable word (pin 95) do not exist. They read 0, and writing them has no effect.
- R11: After reset all status and enable bits, irq_o and rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 95 | Synchronized pin input levels |
| trig_level_i | input | 95 | Per-pin select: 1 level, 0 edge |
| trig_inv_i | input | 95 | Per-pin invert: selects falling edge or high level |
| sense_dis_i | input | 95 | Per-pin input sensing disable |
| gpio_mode_i | input | 95 | Per-pin use-select is general-purpose |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Bus write strobe (1 write, 0 read) |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Registered bus read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
An edge or level is latched in status at the first clock edge that sees the changed pin. A read captures status at the edge that accepts it, so the value is on rdata_o one edge later. irq_o follows status by one further edge. The bench drives pins and bus requests on the falling clock edge and samples just before the next change. In the edge tests it reads status both at the edge that latches the event (the bit is still clear) and at the edge after it (the bit is set). It checks irq_o both one and two edges after a pin change, so an extra or a missing register stage shows up as a miscompare.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] STAT_BASE = 8'h80;
  localparam logic [ADDR_W-1:0] EN_BASE   = 8'h90;

  // {level, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  function automatic logic [ADDR_W-1:0] stat_addr(input int b);
    return STAT_BASE + ADDR_W'(4 * b);
  endfunction

  function automatic logic [ADDR_W-1:0] en_addr(input int b);
    return EN_BASE + ADDR_W'(4 * b);
  endfunction
endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic level_i,
  input  logic inv_i,
  input  logic sense_ok_i,
  output logic evt_o
);
  logic  prev_q;
  logic  hit;
  trig_e mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign mode = trig_e'({level_i, inv_i});

  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = pin_i & ~prev_q;
      TRIG_FALL: hit = ~pin_i & prev_q;
      TRIG_LOW:  hit = ~pin_i;
      default:   hit = pin_i;
    endcase
  end

  assign evt_o = hit & sense_ok_i;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         pend_o
);
  logic [W-1:0] status_q, enable_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt_i;  // new event beats clear
      if (en_we_i) enable_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign pend_o   = |(status_q & enable_q);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] trig_level_i,
  input  logic [NUM_PINS-1:0] trig_inv_i,
  input  logic [NUM_PINS-1:0] sense_dis_i,
  input  logic [NUM_PINS-1:0] gpio_mode_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BANK_W-1:0]   wdata_i,
  output logic [BANK_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int TOT_W     = NUM_BANKS * BANK_W;

  logic [NUM_PINS-1:0]  evt_all;
  logic [TOT_W-1:0]     status_all, enable_all;
  logic [NUM_BANKS-1:0] pend_v;
  logic [BANK_W-1:0]    rd_val, rdata_q;
  logic                 irq_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_pin_det u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[p]),
      .level_i    (trig_level_i[p]),
      .inv_i      (trig_inv_i[p]),
      .sense_ok_i (~sense_dis_i[p] & gpio_mode_i[p]),
      .evt_o      (evt_all[p])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int REM = NUM_PINS - b * BANK_W;
    localparam int W   = (REM >= BANK_W) ? BANK_W : REM;
    logic [W-1:0] st, en;

    gpio_irq_bank #(.W(W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_all[b*BANK_W +: W]),
      .clr_we_i (req_i && we_i && addr_i == stat_addr(b)),
      .en_we_i  (req_i && we_i && addr_i == en_addr(b)),
      .wdata_i  (wdata_i[W-1:0]),
      .status_o (st),
      .enable_o (en),
      .pend_o   (pend_v[b])
    );

    assign status_all[b*BANK_W +: W] = st;
    assign enable_all[b*BANK_W +: W] = en;
    if (W < BANK_W) begin : g_pad
      assign status_all[b*BANK_W+W +: BANK_W-W] = '0;
      assign enable_all[b*BANK_W+W +: BANK_W-W] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == stat_addr(b)) rd_val = status_all[b*BANK_W +: BANK_W];
      if (addr_i == en_addr(b))   rd_val = enable_all[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_q <= rd_val;
      irq_q <= |pend_v;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] sense_dis_i,
  input logic [NUM_PINS-1:0] gpio_mode_i,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [BANK_W-1:0]   wdata_i,
  input logic [BANK_W-1:0]   rdata_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] evt_all,
  input logic [((NUM_PINS+BANK_W-1)/BANK_W)*BANK_W-1:0] status_all,
  input logic [((NUM_PINS+BANK_W-1)/BANK_W)*BANK_W-1:0] enable_all
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam logic [ADDR_W-1:0] LAST_STAT = STAT_BASE + ADDR_W'(4 * (NUM_BANKS - 1));

  // R5: suppressed pins never raise an event
  a_r5_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_all & (sense_dis_i | ~gpio_mode_i)) == '0);

  // R7: a clearing write to word 0 clears the bits without a new event
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == STAT_BASE) |=>
    (status_all[BANK_W-1:0] & $past(wdata_i) & ~$past(evt_all[BANK_W-1:0])) == '0);

  // R8: an event always leaves its status bit set
  a_r8_evt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_all[NUM_PINS-1:0] & $past(evt_all)) == $past(evt_all));

  // R9: irq is the registered OR of status and enable
  a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(status_all & enable_all)));

  // R10: the missing top bit of the last status word reads 0
  a_r10_top_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == LAST_STAT) |=> !rdata_o[BANK_W-1]);

  // R6: an unmapped address reads 0
  a_r6_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 8'hA0) |=> rdata_o == '0);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sense_dis_i (sense_dis_i),
  .gpio_mode_i (gpio_mode_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .evt_all     (evt_all),
  .status_all  (status_all),
  .enable_all  (enable_all)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin = '0, lvl = '0, inv = '0, sdis = '0, gmode = '1;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .trig_level_i(lvl),
    .trig_inv_i(inv), .sense_dis_i(sdis), .gpio_mode_i(gmode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R11 irq", {31'b0, irq}, 32'h0);
    check("R11 rdata", rdata, 32'h0);
    rd(8'h80, d); check("R11 status0", d, 32'h0);
    rd(8'h94, d); check("R11 enable1", d, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    @(negedge clk); pin[5] = 1; req = 1; we = 0; addr = 8'h80;
    @(negedge clk); check("R1 same edge", rdata, 32'h0);
    @(negedge clk); req = 0; check("R1 next edge", rdata, 32'h20);
    wr(8'h80, 32'h20);
    @(negedge clk); pin[5] = 0;
    rd(8'h80, d); check("R1 falling ignored", d, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    @(negedge clk); inv[33] = 1;
    @(negedge clk); pin[33] = 1;
    rd(8'h84, d); check("R2 rising ignored", d, 32'h0);
    @(negedge clk); pin[33] = 0;
    rd(8'h84, d); check("R2 falling", d, 32'h2);
    wr(8'h84, 32'h2);
    @(negedge clk); inv[33] = 0;
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    @(negedge clk); lvl[70] = 1;
    rd(8'h88, d); check("R3 low level", d, 32'h40);
    wr(8'h88, 32'h40);
    rd(8'h88, d); check("R3 clear while low", d, 32'h40);
    @(negedge clk); pin[70] = 1;
    wr(8'h88, 32'h40);
    rd(8'h88, d); check("R3 cleared after high", d, 32'h0);
    @(negedge clk); lvl[70] = 0;
    @(negedge clk); pin[70] = 0;
  endtask

  task automatic t_level_high;
    logic [31:0] d;
    @(negedge clk); lvl[64] = 1; inv[64] = 1;
    rd(8'h88, d); check("R4 low idle", d, 32'h0);
    @(negedge clk); pin[64] = 1;
    rd(8'h88, d); check("R4 high level", d, 32'h1);
    wr(8'h88, 32'h1);
    rd(8'h88, d); check("R4 clear while high", d, 32'h1);
    @(negedge clk); pin[64] = 0;
    wr(8'h88, 32'h1);
    rd(8'h88, d); check("R4 cleared after low", d, 32'h0);
    @(negedge clk); lvl[64] = 0; inv[64] = 0;
  endtask

  task automatic t_suppress;
    logic [31:0] d;
    @(negedge clk); sdis[10] = 1; gmode[11] = 0;
    @(negedge clk); pin[10] = 1; pin[11] = 1;
    rd(8'h80, d); check("R5 suppressed", d, 32'h0);
    @(negedge clk); pin[10] = 0; pin[11] = 0; sdis[10] = 0; gmode[11] = 1;
    @(negedge clk); pin[10] = 1; pin[11] = 1;
    rd(8'h80, d); check("R5 re-enabled", d, 32'hC00);
    wr(8'h80, 32'hFFFF_FFFF);
    @(negedge clk); pin[10] = 0; pin[11] = 0;
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(8'h94, 32'hA5A5_0F0F);
    rd(8'h94, d); check("R6 enable rw", d, 32'hA5A5_0F0F);
    wr(8'hA0, 32'h1234_5678);
    rd(8'hA0, d); check("R6 unmapped read", d, 32'h0);
    rd(8'h94, d); check("R6 unmapped write ignored", d, 32'hA5A5_0F0F);
    rd(8'h8C, d); check("R6 beyond status", d, 32'h0);
    wr(8'h94, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    @(negedge clk); pin[2:0] = 3'b111;
    rd(8'h80, d); check("R7 set", d, 32'h7);
    wr(8'h80, 32'h2);
    rd(8'h80, d); check("R7 clear one", d, 32'h5);
    wr(8'h80, 32'h0);
    rd(8'h80, d); check("R7 zero no effect", d, 32'h5);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R7 clear all", d, 32'h0);
    @(negedge clk); pin[2:0] = 3'b000;
  endtask

  task automatic t_evt_wins;
    logic [31:0] d;
    @(negedge clk); pin[20] = 1;
    @(negedge clk); pin[20] = 0;
    @(negedge clk); pin[20] = 1; req = 1; we = 1; addr = 8'h80; wdata = 32'h0010_0000;
    @(negedge clk); req = 0; we = 0;
    rd(8'h80, d); check("R8 event beats clear", d, 32'h0010_0000);
    wr(8'h80, 32'h0010_0000);
    rd(8'h80, d); check("R8 plain clear", d, 32'h0);
    @(negedge clk); pin[20] = 0;
  endtask

  task automatic t_irq;
    wr(8'h94, 32'h100);
    @(negedge clk); pin[40] = 1;
    @(negedge clk); check("R9 irq one edge", {31'b0, irq}, 32'h0);
    @(negedge clk); check("R9 irq two edges", {31'b0, irq}, 32'h1);
    wr(8'h84, 32'h100);
    check("R9 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R9 irq dropped", {31'b0, irq}, 32'h0);
    @(negedge clk); pin[41] = 1;
    repeat (3) @(negedge clk);
    check("R9 disabled pin no irq", {31'b0, irq}, 32'h0);
    wr(8'h84, 32'hFFFF_FFFF);
    wr(8'h94, 32'h0);
    @(negedge clk); pin[41] = 0; pin[40] = 0;
  endtask

  task automatic t_top_bit;
    logic [31:0] d;
    wr(8'h98, 32'hFFFF_FFFF);
    rd(8'h98, d); check("R10 enable top bit", d, 32'h7FFF_FFFF);
    wr(8'h98, 32'h0);
    @(negedge clk); pin[94] = 1;
    rd(8'h88, d); check("R10 pin 94", d, 32'h4000_0000);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, d); check("R10 status top bit", d, 32'h0);
    @(negedge clk); pin[94] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_rise();
    t_fall();
    t_level_low();
    t_level_high();
    t_suppress();
    t_map();
    t_w1c();
    t_evt_wins();
    t_irq();
    t_top_bit();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule